// File: doc/BRIEF.md
# Multi-Mode Test Observation Register

This block is a small state register that sits between two combinational logic stages. A two-bit mode input gives the register one of four roles. It can latch the upstream logic's outputs as an ordinary pipeline register. It can become a serial shift chain for loading and unloading test state. It can run as a linear-feedback engine that either generates pseudo-random stimulus or compresses a stream of responses into a signature. It can also clear itself.

The stages are numbered S0 up to S(W-1), and bit i of the parallel buses belongs to stage Si. A multiplexer in front of S0 chooses what enters the chain. In shift mode it passes the serial input. In the feedback mode it passes the XOR of the tapped stages. The last stage always drives the serial output, so several registers can be chained into one scan path. A test controller outside the block sequences the modes. A typical sequence is: clear or seed by scan, run the generator or compactor, then scan the signature out.

Top module: `tobs_reg`

## Requirements
- R1: When the synchronous active-high reset `rst` is high at a rising clock edge, all stages become 0 on that edge, whatever the mode.
- R2: With `mode_i` = 2'b10 (load), every stage Si takes `d_i[i]` at the clock edge.
- R3: With `mode_i` = 2'b00 (shift), S0 takes `scan_in_i` and each Si (i > 0) takes the old value of S(i-1).
- R4: With `mode_i` = 2'b01 (clear), all stages become 0 at the clock edge.
- R5: With `mode_i` = 2'b11 (compact), each Si (i > 0) takes `d_i[i]` XOR old S(i-1), and S0 takes `d_i[0]` XOR the feedback. The default feedback is S1 XOR S2. Starting from zero and applying `d_i` = 3'b001, 3'b010, 3'b111, 3'b000 gives `q_o` = 3'b110.
- R6: In compact mode with `d_i` held at zero and the register seeded to S0S1S2 = 100 (`q_o` = 3'b001), the state steps through S0S1S2 = 100, 010, 101, 110, 111, 011, 001 and then returns to 100, a period of 7.
- R7: In compact mode with `d_i` held at zero, an all-zero register stays all-zero.
- R8: `scan_out_o` equals the last stage S(W-1) in every mode, and `q_o` shows all stages, with bit i being Si.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Mode select: 00 shift, 01 clear, 10 load, 11 compact/generate |
| d_i | input | W | Parallel data from the upstream logic |
| scan_in_i | input | 1 | Serial input to S0 in shift mode |
| q_o | output | W | Parallel register contents; bit i is stage Si |
| scan_out_o | output | 1 | Serial output, always the last stage |

## Verification
The generator is seeded with 100 by a three-bit scan and then run with zero data for eight steps. This shows both the full seven-state orbit and the wrap back to the seed. Running the same zero-data pattern from a cleared register separates a correct lock-up from a feedback that injects a constant. A fixed four-word response stream is compacted from zero and compared with a signature worked out by hand, which catches wrong taps or wrong data XOR placement. Long runs with random modes, data, serial bits and occasional resets then test every mode transition against a bench reference model, including reset overriding each mode.

// File: rtl/tobs_pkg.sv
package tobs_pkg;

    // Mode code as seen on the two mode pins.
    typedef enum logic [1:0] {
        MODE_SHIFT   = 2'b00,
        MODE_CLEAR   = 2'b01,
        MODE_LOAD    = 2'b10,
        MODE_COMPACT = 2'b11
    } tobs_mode_e;

    // Decoded one-hot selects that steer every stage.
    typedef struct packed {
        logic load;
        logic shift;
        logic compact;
        logic clear;
    } tobs_sel_t;

    localparam tobs_sel_t SEL_NONE = '{load: 1'b0, shift: 1'b0, compact: 1'b0, clear: 1'b0};

    // Next value of one stage, given its data bit and the bit linked into it.
    function automatic logic stage_next(input tobs_sel_t sel, input logic d_bit, input logic link_bit);
        logic nxt;
        nxt = 1'b0;
        if (sel.load)    nxt = d_bit;
        if (sel.shift)   nxt = link_bit;
        if (sel.compact) nxt = d_bit ^ link_bit;
        if (sel.clear)   nxt = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/tobs_mode_dec.sv
module tobs_mode_dec
    import tobs_pkg::*;
(
    input  logic [1:0] mode_i,
    output tobs_sel_t  sel_o
);

    always_comb begin
        sel_o = SEL_NONE;
        unique case (tobs_mode_e'(mode_i))
            MODE_LOAD:    sel_o.load    = 1'b1;
            MODE_SHIFT:   sel_o.shift   = 1'b1;
            MODE_COMPACT: sel_o.compact = 1'b1;
            MODE_CLEAR:   sel_o.clear   = 1'b1;
            default:      sel_o = SEL_NONE;
        endcase
    end

    // R2 R3 R4 R5: each known mode code enables exactly one stage function
    always_comb begin
        if (!$isunknown(mode_i)) begin
            sel_onehot_chk: assert ($countones(sel_o) == 1)
                else $error("mode decode not one-hot");
        end
    end

endmodule

// File: rtl/tobs_feedback.sv
module tobs_feedback #(
    parameter int unsigned     W    = 3,
    parameter logic [W-1:0]    TAPS = 3'b110
) (
    input  logic [W-1:0] state_i,
    input  logic         shift_i,
    input  logic         scan_in_i,
    output logic         link0_o
);

    logic fb;

    // XOR of the tapped stages
    always_comb fb = ^(state_i & TAPS);

    // Front multiplexer of stage 0: serial input while shifting, feedback otherwise
    always_comb link0_o = shift_i ? scan_in_i : fb;

endmodule

// File: rtl/tobs_stage.sv
module tobs_stage
    import tobs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tobs_sel_t sel_i,
    input  logic      d_i,
    input  logic      link_i,
    output logic      q_o
);

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= stage_next(sel_i, d_i, link_i);
    end

endmodule

// File: rtl/tobs_reg.sv
module tobs_reg
    import tobs_pkg::*;
#(
    parameter int unsigned  W    = 3,
    parameter logic [W-1:0] TAPS = 3'b110
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] d_i,
    input  logic         scan_in_i,
    output logic [W-1:0] q_o,
    output logic         scan_out_o
);

    localparam int unsigned LAST = W - 1;

    tobs_sel_t    sel;
    logic [W-1:0] state;
    logic [W-1:0] link;

    tobs_mode_dec u_dec (
        .mode_i (mode_i),
        .sel_o  (sel)
    );

    tobs_feedback #(.W(W), .TAPS(TAPS)) u_fb (
        .state_i   (state),
        .shift_i   (sel.shift),
        .scan_in_i (scan_in_i),
        .link0_o   (link[0])
    );

    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i > 0) begin : g_link
            assign link[i] = state[i-1];
        end
        tobs_stage u_stage (
            .clk    (clk),
            .rst    (rst),
            .sel_i  (sel),
            .d_i    (d_i[i]),
            .link_i (link[i]),
            .q_o    (state[i])
        );
    end

    assign q_o        = state;
    assign scan_out_o = state[LAST];

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (q_o == '0))
        else $error("reset did not clear");

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10) |=> (q_o == $past(d_i)))
        else $error("load mode mismatch");

    // R3
    shift_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |=> (q_o[0] == $past(scan_in_i)) && (q_o[LAST:1] == $past(q_o[LAST-1:0])))
        else $error("shift mode mismatch");

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01) |=> (q_o == '0))
        else $error("clear mode mismatch");

    // R5
    compact_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> (q_o[LAST:1] == $past(d_i[LAST:1] ^ q_o[LAST-1:0])))
        else $error("compact chain mismatch");

    // R5
    compact_head_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> (q_o[0] == $past(d_i[0] ^ (^(q_o & TAPS)))))
        else $error("compact head mismatch");

    // R7
    lockup_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11 && d_i == '0 && q_o == '0) |=> (q_o == '0))
        else $error("zero state left with zero data");

endmodule

// File: tb/tobs_reg_tb_top.sv
module tobs_reg_tb_top;

    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   mode;
    logic [W-1:0] d;
    logic         si;
    logic [W-1:0] q;
    logic         so;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q;

    always #2.5 clk = ~clk;

    tobs_reg #(.W(W), .TAPS(3'b110)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .d_i        (d),
        .scan_in_i  (si),
        .q_o        (q),
        .scan_out_o (so)
    );

    // Reference model taken from the requirements
    function automatic logic [W-1:0] model_next(logic [W-1:0] s, logic r, logic [1:0] m,
                                                logic [W-1:0] dd, logic sin);
        logic [W-1:0] n;
        if (r) return '0;
        case (m)
            2'b10: n = dd;
            2'b00: n = {s[W-2:0], sin};
            2'b01: n = '0;
            default: begin
                n[0] = dd[0] ^ s[1] ^ s[2];
                for (int i = 1; i < W; i++) n[i] = dd[i] ^ s[i-1];
            end
        endcase
        return n;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s q actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_so(string req);
        checks++;
        if (so !== q[W-1]) begin
            errors++;
            $display("FAIL %s scan_out actual=%b expected=%b", req, so, q[W-1]);
        end
    endtask

    // Drive one cycle at the falling edge, sample after the next rising edge
    task automatic step(logic r, logic [1:0] m, logic [W-1:0] dd, logic sin);
        @(negedge clk);
        rst = r; mode = m; d = dd; si = sin;
        exp_q = model_next(exp_q, r, m, dd, sin);
        @(posedge clk);
        #1;
    endtask

    logic [W-1:0] orbit [0:7];

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; mode = 2'b10; d = 3'b111; si = 1'b1;
        exp_q = '0;
        step(1'b1, 2'b10, 3'b111, 1'b1);
        check("R1 reset over load", q, 3'b000);
        check_so("R8 after reset");

        // R2 load
        step(1'b0, 2'b10, 3'b101, 1'b0);
        check("R2 load 101", q, 3'b101);
        check_so("R8 load");
        // R1 reset overrides load
        step(1'b1, 2'b10, 3'b011, 1'b0);
        check("R1 reset priority", q, 3'b000);

        // R3 seed S0S1S2=100 by scan: shift 0,0,1
        step(1'b0, 2'b00, 3'b111, 1'b0);
        step(1'b0, 2'b00, 3'b111, 1'b0);
        step(1'b0, 2'b00, 3'b111, 1'b1);
        check("R3 scan seed", q, 3'b001);
        check_so("R8 scan");

        // R6 generator orbit (q bit0=S0)
        orbit[0] = 3'b010; orbit[1] = 3'b101; orbit[2] = 3'b011; orbit[3] = 3'b111;
        orbit[4] = 3'b110; orbit[5] = 3'b100; orbit[6] = 3'b001; orbit[7] = 3'b010;
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 2'b11, 3'b000, 1'b0);
            check("R6 generator orbit", q, orbit[k]);
            check_so("R8 generator");
        end

        // R4 clear
        step(1'b0, 2'b01, 3'b111, 1'b1);
        check("R4 clear", q, 3'b000);

        // R7 lock-up
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 2'b11, 3'b000, 1'b1);
            check("R7 zero lock", q, 3'b000);
        end

        // R5 known signature
        step(1'b0, 2'b11, 3'b001, 1'b0);
        step(1'b0, 2'b11, 3'b010, 1'b0);
        step(1'b0, 2'b11, 3'b111, 1'b0);
        step(1'b0, 2'b11, 3'b000, 1'b0);
        check("R5 signature", q, 3'b110);

        // R3 scan the signature out: bits appear on scan_out S2,S1,S0
        step(1'b0, 2'b00, 3'b000, 1'b0);
        check("R3 scan out shift", q, 3'b100);
        checks++;
        if (so !== 1'b1) begin
            errors++;
            $display("FAIL R3 scan_out actual=%b expected=%b", so, 1'b1);
        end

        // Random mix of all modes, checked against the model
        for (int k = 0; k < 600; k++) begin
            logic r;
            r = ($urandom_range(0, 31) == 0);
            step(r, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
            check("R1 R2 R3 R4 R5 random", q, exp_q);
            check_so("R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule